// File: doc/BRIEF.md
# Burst Address Generator

This block sits on the slave side of an AXI channel. It accepts a single burst description: the first byte address, a 4-bit length code, a 3-bit size code and a 2-bit burst type. It then produces one beat at a time. Each beat carries the byte address and the byte-lane enable mask for a data bus whose width is set by a parameter. The master supplies only the first address, and the block works out every later address itself.

A consumer reads `beat_addr`, `beat_strb` and `beat_last` while `beat_valid` is high. It raises `beat_adv` to move to the next beat. The burst always runs for exactly the encoded number of beats. A new burst can be accepted in the same cycle that the final beat is consumed, so two bursts can run back to back with no idle cycle between them. All beat outputs come from registers.

Top module: `axi_burst_addr_gen`

## Requirements
- R1: `start_ready` is high whenever no beat is pending. When `start_valid` and `start_ready` are both high at a clock edge, the burst is captured. On the next cycle `beat_valid` is 1 and `beat_addr` equals `start_addr`.
- R2: A burst presents exactly `start_len`+1 beats. `beat_last` is 1 only on the beat whose index equals the length code. After that beat is consumed with no new start, `beat_valid` returns to 0.
- R3: For type code 01 (incrementing), and for the reserved code 11, which behaves the same way, each later beat address is the previous address aligned down to 2^size bytes, plus 2^size.
- R4: For type code 10 (wrapping), the window is (len+1)·2^size bytes, aligned to its own size. When the next address would reach the window's end, it rolls back to the window's start.
- R5: For type code 00 (fixed), every beat repeats the start address and the same lane mask.
- R6: Only address bits [11:0] are ever updated. Bits above 11 keep the start address value for the whole burst.
- R7: `beat_strb` bit i (lane i) is 1 exactly when i ≥ addr mod DATA_BYTES and i < (addr aligned down to 2^size) mod DATA_BYTES + 2^size. As a result, an unaligned first beat masks off the lanes below the start address.
- R8: While `beat_valid` is 1 and `beat_adv` is 0, the address, mask, last flag and valid flag hold their values.
- R9: A `start_valid` raised while a beat that is not the final beat is pending is ignored: `start_ready` is 0, and the running burst continues unchanged.
- R10: If the final beat is consumed and `start_valid` is high in the same cycle, the new burst is accepted. Its first beat appears on the next cycle with no gap.
- R11: A synchronous active-high `rst` clears `beat_valid` and `beat_last` and leaves `start_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Burst description offered |
| start_ready | output | 1 | Burst description can be taken this cycle |
| start_addr | input | ADDR_W | First byte address |
| start_len | input | 4 | Beats minus one |
| start_size | input | 3 | log2 of bytes per beat |
| start_type | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 as 01 |
| beat_valid | output | 1 | A beat is presented |
| beat_adv | input | 1 | Consumer takes the presented beat |
| beat_addr | output | ADDR_W | Byte address of the presented beat |
| beat_strb | output | DATA_BYTES | Byte-lane enables of the presented beat |
| beat_last | output | 1 | Presented beat is the final one |

## Verification
Two events can fall in the same cycle: the final beat being consumed and a new burst being accepted. The bench provokes this by holding `beat_adv` and `start_valid` high together on a final beat. It then expects `start_ready` to be 1 in that cycle, and expects the new burst's first address, mask and last flag one cycle later with `beat_valid` never dropping. The opposite case is also exercised: a start offered on a beat that is not the final one. There the bench judges the result by confirming that the next beat still follows the old burst's address sequence.

// File: rtl/abg_pkg.sv
package abg_pkg;
  localparam int PAGE_BITS = 12;
  localparam int LEN_W     = 4;
  localparam int SIZE_W    = 3;

  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  typedef struct packed {
    burst_e              btype;
    logic [SIZE_W-1:0]   size;
    logic [LEN_W-1:0]    len;
  } burst_cfg_t;
endpackage

// File: rtl/abg_next_addr.sv
module abg_next_addr
  import abg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  burst_cfg_t        cfg,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [PAGE_BITS-1:0] lo, step, aligned, bumped, wmask, wrapped;

  always_comb begin
    lo      = cur_addr[PAGE_BITS-1:0];
    step    = PAGE_BITS'(1) << cfg.size;
    aligned = lo & ~(step - PAGE_BITS'(1));
    bumped  = aligned + step;
    wmask   = ((PAGE_BITS'(cfg.len) + PAGE_BITS'(1)) << cfg.size) - PAGE_BITS'(1);
    wrapped = (lo & ~wmask) | (bumped & wmask);
    unique case (cfg.btype)
      BT_FIXED: nxt_addr = cur_addr;
      BT_WRAP:  nxt_addr = {cur_addr[ADDR_W-1:PAGE_BITS], wrapped};
      default:  nxt_addr = {cur_addr[ADDR_W-1:PAGE_BITS], bumped};
    endcase
  end
endmodule

// File: rtl/abg_lane_mask.sv
module abg_lane_mask
  import abg_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  localparam int LANE_W    = $clog2(DATA_BYTES)
) (
  input  logic [LANE_W-1:0] addr_low,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_BYTES-1:0] strb
);
  localparam int CW = 9;
  logic [CW-1:0] nb, first, algn, stop;

  always_comb begin
    nb    = CW'(1) << size;
    first = CW'(addr_low);
    algn  = first & ~(nb - CW'(1));
    stop  = algn + nb;
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    assign strb[i] = (CW'(i) >= first) && (CW'(i) < stop);
  end
endmodule

// File: rtl/abg_beat_ctrl.sv
module abg_beat_ctrl
  import abg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_valid,
  input  logic [LEN_W-1:0] start_len,
  input  logic             beat_adv,
  output logic             start_ready,
  output logic             load,
  output logic             advance,
  output logic             valid,
  output logic             last
);
  logic [LEN_W-1:0] idx_q, len_q;
  logic             taken;

  assign taken       = valid & beat_adv;
  assign start_ready = ~valid | (taken & last);
  assign load        = start_valid & start_ready;
  assign advance     = taken & ~last;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      last  <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else if (load) begin
      valid <= 1'b1;
      idx_q <= '0;
      len_q <= start_len;
      last  <= (start_len == '0);
    end else if (taken) begin
      if (last) begin
        valid <= 1'b0;
        last  <= 1'b0;
      end else begin
        idx_q <= idx_q + LEN_W'(1);
        last  <= ((idx_q + LEN_W'(1)) == len_q);
      end
    end
  end
endmodule

// File: rtl/axi_burst_addr_gen.sv
module axi_burst_addr_gen
  import abg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_valid,
  output logic                  start_ready,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic [3:0]            start_len,
  input  logic [2:0]            start_size,
  input  logic [1:0]            start_type,
  output logic                  beat_valid,
  input  logic                  beat_adv,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic                  beat_last
);
  localparam int LANE_W = $clog2(DATA_BYTES);

  burst_cfg_t            cfg_q, cfg_in;
  logic [ADDR_W-1:0]     addr_q, nxt_addr, mask_addr;
  logic [DATA_BYTES-1:0] strb_q, strb_nxt;
  logic [SIZE_W-1:0]     mask_size;
  logic                  load, advance;

  assign cfg_in = '{btype: burst_e'(start_type), size: start_size, len: start_len};

  abg_beat_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_len   (start_len),
    .beat_adv    (beat_adv),
    .start_ready (start_ready),
    .load        (load),
    .advance     (advance),
    .valid       (beat_valid),
    .last        (beat_last)
  );

  abg_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .cur_addr (addr_q),
    .cfg      (cfg_q),
    .nxt_addr (nxt_addr)
  );

  assign mask_addr = load ? start_addr : nxt_addr;
  assign mask_size = load ? start_size : cfg_q.size;

  abg_lane_mask #(.DATA_BYTES(DATA_BYTES)) u_mask (
    .addr_low (mask_addr[LANE_W-1:0]),
    .size     (mask_size),
    .strb     (strb_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      strb_q <= '0;
      cfg_q  <= '0;
    end else if (load) begin
      addr_q <= start_addr;
      strb_q <= strb_nxt;
      cfg_q  <= cfg_in;
    end else if (advance) begin
      addr_q <= nxt_addr;
      strb_q <= strb_nxt;
    end
  end

  assign beat_addr = addr_q;
  assign beat_strb = strb_q;
endmodule

// File: rtl/abg_checker.sv
module abg_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start_valid,
  input logic                  start_ready,
  input logic [1:0]            start_type,
  input logic [2:0]            start_size,
  input logic                  beat_valid,
  input logic                  beat_adv,
  input logic                  beat_last,
  input logic [ADDR_W-1:0]     beat_addr,
  input logic [DATA_BYTES-1:0] beat_strb
);
  logic [1:0] held_type;
  logic [2:0] held_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_type <= 2'b01;
      held_size <= 3'd0;
    end else if (start_valid && start_ready) begin
      held_type <= start_type;
      held_size <= start_size;
    end
  end

  p_last_in_beat_r2: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  p_ends_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_adv && beat_last && !start_valid) |=> !beat_valid);

  p_accept_shows_beat_r1: assert property (@(posedge clk) disable iff (rst)
    (start_valid && start_ready) |=> beat_valid);

  p_fixed_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_adv && !beat_last && held_type == 2'b00) |=>
      (beat_addr == $past(beat_addr) && beat_strb == $past(beat_strb)));

  p_page_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_adv && !beat_last) |=>
      (beat_addr[ADDR_W-1:12] == $past(beat_addr[ADDR_W-1:12])));

  p_lane_count_r7: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> ($countones(beat_strb) >= 1 &&
                    $countones(beat_strb) <= (1 << held_size)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_adv) |=>
      (beat_valid && $stable(beat_addr) && $stable(beat_strb) && $stable(beat_last)));

  p_busy_refuses_r9: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last) |-> !start_ready);
endmodule

bind axi_burst_addr_gen abg_checker #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .start_type  (start_type),
  .start_size  (start_size),
  .beat_valid  (beat_valid),
  .beat_adv    (beat_adv),
  .beat_last   (beat_last),
  .beat_addr   (beat_addr),
  .beat_strb   (beat_strb)
);

// File: tb/axi_burst_addr_gen_bench.sv
module axi_burst_addr_gen_bench;
  localparam int AW = 32;
  localparam int DB = 8;
  localparam int NV = 8;

  localparam logic [31:0] V_ADDR  [NV] = '{32'h1000, 32'h2003, 32'h3038, 32'h4005,
                                           32'h5000, 32'h7FF8, 32'h8005, 32'h9006};
  localparam logic [3:0]  V_LEN   [NV] = '{4'd3, 4'd2, 4'd3, 4'd2, 4'd1, 4'd1, 4'd15, 4'd0};
  localparam logic [2:0]  V_SIZE  [NV] = '{3'd2, 3'd2, 3'd3, 3'd0, 3'd1, 3'd3, 3'd0, 3'd1};
  localparam logic [1:0]  V_TYPE  [NV] = '{2'b01, 2'b01, 2'b10, 2'b00, 2'b11, 2'b01, 2'b10, 2'b01};
  localparam logic [31:0] V_LASTA [NV] = '{32'h100C, 32'h2008, 32'h3030, 32'h4005,
                                           32'h5002, 32'h7000, 32'h8004, 32'h9006};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [AW-1:0] start_addr = '0;
  logic [3:0]    start_len = '0;
  logic [2:0]    start_size = '0;
  logic [1:0]    start_type = '0;
  logic          beat_valid;
  logic          beat_adv = 1'b0;
  logic [AW-1:0] beat_addr;
  logic [DB-1:0] beat_strb;
  logic          beat_last;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  axi_burst_addr_gen #(.ADDR_W(AW), .DATA_BYTES(DB)) u_axi_burst_addr_gen (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .start_addr(start_addr), .start_len(start_len), .start_size(start_size),
    .start_type(start_type), .beat_valid(beat_valid), .beat_adv(beat_adv),
    .beat_addr(beat_addr), .beat_strb(beat_strb), .beat_last(beat_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_next(input logic [31:0] a, input int size,
                                           input int len, input logic [1:0] typ);
    int nb, al, wl, bnd, off;
    nb = 1 << size;
    al = int'(a[11:0]) - (int'(a[11:0]) % nb);
    if (typ == 2'b00) return a;
    if (typ == 2'b10) begin
      wl  = (len + 1) * nb;
      bnd = int'(a[11:0]) - (int'(a[11:0]) % wl);
      off = al + nb - bnd;
      if (off == wl) return {a[31:12], 12'(bnd)};
      return {a[31:12], 12'(bnd + off)};
    end
    return {a[31:12], 12'((al + nb) % 4096)};
  endfunction

  function automatic logic [DB-1:0] ref_strb(input logic [31:0] a, input int size);
    int nb, lo, top;
    logic [DB-1:0] m;
    nb  = 1 << size;
    lo  = int'(a) % DB;
    top = (lo - (lo % nb)) + nb;
    m = '0;
    for (int i = 0; i < DB; i++) m[i] = (i >= lo) && (i < top);
    return m;
  endfunction

  function automatic string req_of(input int v);
    if (v == 5) return "R6";
    case (V_TYPE[v])
      2'b00: return "R5";
      2'b10: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic run_burst(input int v);
    logic [31:0] a;
    string rq;
    rq = req_of(v);
    @(negedge clk);
    start_valid = 1'b1; start_addr = V_ADDR[v]; start_len = V_LEN[v];
    start_size = V_SIZE[v]; start_type = V_TYPE[v];
    @(negedge clk);
    start_valid = 1'b0;
    a = V_ADDR[v];
    for (int k = 0; k <= int'(V_LEN[v]); k++) begin
      chk(beat_valid, "R1", "valid", 32'(beat_valid), 32'd1);
      chk(beat_addr == a, rq, "addr", beat_addr, a);
      chk(beat_strb == ref_strb(a, int'(V_SIZE[v])), "R7", "strb",
          32'(beat_strb), 32'(ref_strb(a, int'(V_SIZE[v]))));
      chk(beat_last == (k == int'(V_LEN[v])), "R2", "last", 32'(beat_last),
          32'(k == int'(V_LEN[v])));
      if (k == int'(V_LEN[v]))
        chk(beat_addr == V_LASTA[v], rq, "final addr", beat_addr, V_LASTA[v]);
      beat_adv = 1'b1;
      a = ref_next(a, int'(V_SIZE[v]), int'(V_LEN[v]), V_TYPE[v]);
      @(negedge clk);
    end
    beat_adv = 1'b0;
    chk(!beat_valid, "R2", "valid after end", 32'(beat_valid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!beat_valid, "R11", "reset valid", 32'(beat_valid), 32'd0);
    chk(!beat_last, "R11", "reset last", 32'(beat_last), 32'd0);
    chk(start_ready, "R11", "reset ready", 32'(start_ready), 32'd1);

    for (int v = 0; v < NV; v++) run_burst(v);

    // R8 stall, R9 ignored start, R10 back-to-back
    @(negedge clk);
    start_valid = 1'b1; start_addr = 32'hA000; start_len = 4'd3;
    start_size = 3'd2; start_type = 2'b01;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(beat_valid && beat_addr == 32'hA000, "R8", "stall addr", beat_addr, 32'hA000);
    chk(beat_strb == 8'h0F, "R8", "stall strb", 32'(beat_strb), 32'h0F);
    start_valid = 1'b1; start_addr = 32'hB000; start_len = 4'd0; start_type = 2'b00;
    beat_adv = 1'b1;
    #1;
    chk(!start_ready, "R9", "ready while busy", 32'(start_ready), 32'd0);
    @(negedge clk);
    start_valid = 1'b0;
    chk(beat_addr == 32'hA004, "R9", "addr after ignored start", beat_addr, 32'hA004);
    @(negedge clk);
    chk(beat_addr == 32'hA008, "R9", "third addr", beat_addr, 32'hA008);
    @(negedge clk);
    chk(beat_last && beat_addr == 32'hA00C, "R2", "last addr", beat_addr, 32'hA00C);
    start_valid = 1'b1; start_addr = 32'hC010; start_len = 4'd0;
    start_size = 3'd3; start_type = 2'b01;
    #1;
    chk(start_ready, "R10", "ready on last", 32'(start_ready), 32'd1);
    @(negedge clk);
    start_valid = 1'b0;
    chk(beat_valid, "R10", "no gap", 32'(beat_valid), 32'd1);
    chk(beat_addr == 32'hC010, "R10", "new first addr", beat_addr, 32'hC010);
    chk(beat_strb == 8'hFF, "R10", "new strb", 32'(beat_strb), 32'hFF);
    chk(beat_last, "R10", "new last", 32'(beat_last), 32'd1);
    @(negedge clk);
    beat_adv = 1'b0;
    chk(!beat_valid, "R2", "idle after single", 32'(beat_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule